// File: doc/BRIEF.md
# Vector Lane Copy and Insert Unit

This execute-stage unit decodes and carries out the lane-copy instruction group of a 128-bit SIMD datapath. It can broadcast one vector lane, or a general-purpose register value, into every lane of the result. It can replace a single lane with a general-purpose value or with a lane taken from another vector. It can also move one lane to a general-purpose register, with sign or zero extension. A scalar form pulls one lane out of a vector and zero-extends it into a 64-bit scalar destination.

The surrounding pipeline supplies the following inputs:

- the 32-bit instruction word;
- the vector source register value;
- the current value of the vector destination;
- one 64-bit general operand.

The unit returns one vector result and one general result, each with its own write enable, and an undefined-instruction flag. The decode and data path are combinational. A single register stage, qualified by a valid bit, gives a latency of one cycle. Register-file storage, forwarding and exception handling are left to the surrounding pipeline.

Top module: `lane_copy_unit`

## Requirements
- R1: While reset is held, and after it until the first valid input, `out_valid`, `vec_we`, `gen_we` and `undef_insn` are all 0.
- R2: An instruction presented with `in_valid` high yields its outputs, with `out_valid` high, on the following clock edge. A cycle with `in_valid` low yields `out_valid` low on the next edge.
- R3: Lane size is the position of the lowest set bit of imm5 (`instr[20:16]`): 0 selects 8-bit, 1 selects 16-bit, 2 selects 32-bit and 3 selects 64-bit lanes. The lane index is imm5 shifted right by size+1. If `instr[19:16]` is 0, the word is undefined.
- R4: Vector form is `instr[31]`=0, `instr[28:21]`=01110000, `instr[15]`=0 and `instr[10]`=1. Q is `instr[30]`, op is `instr[29]` and imm4 is `instr[14:11]`. With op=0 and imm4=0000, the selected source lane is copied into every lane. Q=1 gives all 16 bytes. Q=0 fills bytes 7:0 and clears bytes 15:8. A 64-bit lane with Q=0 is undefined.
- R5: With op=0 and imm4=0001, the low lane-width bits of the general operand are broadcast, using the same width and legality rules as R4.
- R6: With op=0, imm4=0011 and Q=1, the low lane-width bits of the general operand replace the indexed lane of the old destination, and all other lanes are kept. With Q=0 the word is undefined.
- R7: With op=1 and Q=1, the destination lane (indexed from imm5) of the old destination is replaced by the source lane at index imm4 shifted right by size. With op=1 and Q=0 the word is undefined.
- R8: With op=0 and imm4=0101, the indexed lane is sign-extended to 64 bits and written to the general result. When Q=0 the upper 32 bits are cleared. A 64-bit lane is undefined, and a 32-bit lane with Q=0 is undefined.
- R9: With op=0 and imm4=0111, the indexed lane is zero-extended to the general result. The word is legal only when (lane size is 64-bit) equals Q.
- R10: The scalar form (`instr[31:21]`=01011110000, `instr[15:10]`=000001) writes the indexed lane, zero-extended, into bits 63:0 of the vector result, with bits 127:64 zero.
- R11: Any other word, including any other imm4 value with op=0, is undefined. An undefined word raises `undef_insn` and keeps both write enables low.
- R12: The broadcast, insert and scalar forms raise only `vec_we`. The move forms raise only `gen_we`. The two enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| vec_src | input | 128 | Vector source register value |
| vec_old | input | 128 | Current value of the vector destination |
| gen_src | input | 64 | General-purpose operand |
| out_valid | output | 1 | Registered outputs are valid |
| vec_we | output | 1 | Write `vec_result` to the vector destination |
| gen_we | output | 1 | Write `gen_result` to the general destination |
| undef_insn | output | 1 | Word is an undefined encoding |
| vec_result | output | 128 | Vector result |
| gen_result | output | 64 | General result |

## Verification
The hardest situations to reach from the ports are the narrow legality edges. These are an immediate whose low four bits are all zero, an unsigned move whose Q does not match a 64-bit lane, a 32-bit signed move with Q=0, and lane-insert words whose source immediate carries bits below the lane size. A directed test covers only a few of these. The stimulus therefore sweeps every imm5 value against both Q values and every imm4 value, for both op values and for the scalar form. Each word uses fresh random operands, so every lane position is checked with distinct data against a lane-by-lane model in the bench.

// File: rtl/lane_copy_unit.sv
module lane_copy_unit (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  instr,
  input  logic [127:0] vec_src,
  input  logic [127:0] vec_old,
  input  logic [63:0]  gen_src,
  output logic         out_valid,
  output logic         vec_we,
  output logic         gen_we,
  output logic         undef_insn,
  output logic [127:0] vec_result,
  output logic [63:0]  gen_result
);

  logic [4:0] imm5;
  logic [3:0] imm4;
  logic       q, op;
  logic       unused_fields;

  assign imm5 = instr[20:16];
  assign imm4 = instr[14:11];
  assign q    = instr[30];
  assign op   = instr[29];
  assign unused_fields = ^instr[9:0];

  logic is_vec, is_scl;
  assign is_vec = !instr[31] && instr[28:21] == 8'b01110000 && !instr[15] && instr[10];
  assign is_scl = instr[31:21] == 11'b01011110000 && instr[15:10] == 6'b000001;

  logic [1:0] sz;
  logic       sz_ok;
  always_comb begin
    sz_ok = 1'b1;
    casez (imm5[3:0])
      4'b???1: sz = 2'd0;
      4'b??10: sz = 2'd1;
      4'b?100: sz = 2'd2;
      4'b1000: sz = 2'd3;
      default: begin sz = 2'd0; sz_ok = 1'b0; end
    endcase
  end

  logic [3:0] didx, sidx, ridx;
  logic       ins_elem;
  assign didx     = 4'(imm5 >> (3'(sz) + 3'd1));
  assign sidx     = imm4 >> sz;
  assign ins_elem = is_vec && op;
  assign ridx     = ins_elem ? sidx : didx;

  logic [6:0] dpos, spos;
  assign dpos = {didx, 3'b000} << sz;
  assign spos = {ridx, 3'b000} << sz;

  logic [63:0] smask;
  assign smask = (sz == 2'd3) ? {64{1'b1}} : (64'd1 << (7'd8 << sz)) - 64'd1;

  logic [127:0] shifted;
  logic [63:0]  lane, gval;
  assign shifted = vec_src >> spos;
  assign lane    = shifted[63:0] & smask;
  assign gval    = gen_src & smask;

  function automatic logic [63:0] replicate(input logic [63:0] v, input logic [1:0] s);
    case (s)
      2'd0:    replicate = {8{v[7:0]}};
      2'd1:    replicate = {4{v[15:0]}};
      2'd2:    replicate = {2{v[31:0]}};
      default: replicate = v;
    endcase
  endfunction

  logic [63:0] sext;
  always_comb begin
    case (sz)
      2'd0:    sext = {{56{lane[7]}}, lane[7:0]};
      2'd1:    sext = {{48{lane[15]}}, lane[15:0]};
      default: sext = {{32{lane[31]}}, lane[31:0]};
    endcase
  end

  logic [63:0]  bval, ival;
  logic [127:0] vins, vbc;
  assign ival = ins_elem ? lane : gval;
  assign vins = (vec_old & ~({64'd0, smask} << dpos)) | ({64'd0, ival} << dpos);
  assign bval = replicate((imm4[0] ? gval : lane), sz);
  assign vbc  = {q ? bval : 64'd0, bval};

  logic         c_undef, c_vwe, c_gwe;
  logic [127:0] c_vres;
  logic [63:0]  c_gres;

  always_comb begin
    c_undef = 1'b1;
    c_vwe   = 1'b0;
    c_gwe   = 1'b0;
    c_vres  = vins;
    c_gres  = lane;
    if (sz_ok && is_scl) begin
      c_undef = 1'b0;
      c_vwe   = 1'b1;
      c_vres  = {64'd0, lane};
    end else if (sz_ok && is_vec) begin
      if (op) begin
        if (q) begin
          c_undef = 1'b0;
          c_vwe   = 1'b1;
        end
      end else begin
        case (imm4)
          4'b0000, 4'b0001: if (!(sz == 2'd3 && !q)) begin
            c_undef = 1'b0;
            c_vwe   = 1'b1;
            c_vres  = vbc;
          end
          4'b0011: if (q) begin
            c_undef = 1'b0;
            c_vwe   = 1'b1;
          end
          4'b0101: if (sz < 2'd2 || (sz == 2'd2 && q)) begin
            c_undef = 1'b0;
            c_gwe   = 1'b1;
            c_gres  = q ? sext : {32'd0, sext[31:0]};
          end
          4'b0111: if ((sz == 2'd3) == q) begin
            c_undef = 1'b0;
            c_gwe   = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      vec_we     <= 1'b0;
      gen_we     <= 1'b0;
      undef_insn <= 1'b0;
      vec_result <= '0;
      gen_result <= '0;
    end else begin
      out_valid  <= in_valid;
      vec_we     <= in_valid && c_vwe;
      gen_we     <= in_valid && c_gwe;
      undef_insn <= in_valid && c_undef;
      if (in_valid) begin
        vec_result <= c_vres;
        gen_result <= c_gres;
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!vec_we && !gen_we && !undef_insn));

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r3_no_size_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[19:16] == 4'd0) |=> undef_insn);

  a_r4_half_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:21] == 11'b00001110000 && instr[15:12] == 4'b0000 && instr[10])
      |=> (!vec_we || vec_result[127:64] == 64'd0));

  a_r8_narrow_signed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:21] == 11'b00001110000 && instr[15:10] == 6'b001011)
      |=> (!gen_we || gen_result[63:32] == 32'd0));

  a_r11_undef_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    undef_insn |-> (!vec_we && !gen_we));

  a_r12_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_we && gen_we));

endmodule

// File: tb/lane_copy_unit_tb_top.sv
`timescale 1ns/1ps
module lane_copy_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] vec_src = '0, vec_old = '0;
  logic [63:0]  gen_src = '0;
  logic         out_valid, vec_we, gen_we, undef_insn;
  logic [127:0] vec_result;
  logic [63:0]  gen_result;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  lane_copy_unit dut_i (.clk, .rst_n, .in_valid, .instr, .vec_src, .vec_old, .gen_src,
    .out_valid, .vec_we, .gen_we, .undef_insn, .vec_result, .gen_result);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] getl(input logic [127:0] v, input int i, input int s);
    int w = 8 << s;
    logic [63:0] r = '0;
    for (int b = 0; b < w; b++) r[b] = v[i*w + b];
    return r;
  endfunction

  function automatic logic [127:0] setl(input logic [127:0] v, input int i, input int s,
                                        input logic [63:0] x);
    int w = 8 << s;
    logic [127:0] r = v;
    for (int b = 0; b < w; b++) r[i*w + b] = x[b];
    return r;
  endfunction

  task automatic model(input logic [31:0] w, input logic [127:0] vs, input logic [127:0] vd,
                       input logic [63:0] g, output bit u, output bit vw, output bit gw,
                       output logic [127:0] vr, output logic [63:0] gr);
    int s = -1, idx, nl, wd;
    logic [4:0] i5 = w[20:16];
    logic [3:0] i4 = w[14:11];
    bit q = w[30], op = w[29];
    bit isv = (w[31] == 0) && (w[28:21] == 8'b01110000) && (w[15] == 0) && (w[10] == 1);
    bit iss = (w[31:21] == 11'b01011110000) && (w[15:10] == 6'b000001);
    logic [63:0] x;
    u = 1; vw = 0; gw = 0; vr = '0; gr = '0;
    for (int k = 0; k < 4; k++) if (s < 0 && i5[k]) s = k;
    if (s < 0) return;
    idx = int'(i5) >> (s + 1);
    wd = 8 << s;
    nl = (q ? 16 : 8) >> s;
    if (iss) begin
      u = 0; vw = 1; vr = {64'd0, getl(vs, idx, s)};
    end else if (isv && op) begin
      if (q) begin
        u = 0; vw = 1; vr = setl(vd, idx, s, getl(vs, int'(i4) >> s, s));
      end
    end else if (isv) begin
      case (i4)
        4'd0, 4'd1: if (!(s == 3 && !q)) begin
          x = (i4 == 4'd0) ? getl(vs, idx, s) : getl({64'd0, g}, 0, s);
          for (int l = 0; l < nl; l++) vr = setl(vr, l, s, x);
          u = 0; vw = 1;
        end
        4'd3: if (q) begin
          u = 0; vw = 1; vr = setl(vd, idx, s, getl({64'd0, g}, 0, s));
        end
        4'd5: if (s < 2 || (s == 2 && q)) begin
          x = getl(vs, idx, s);
          if (x[wd-1]) x = x | ~((64'd1 << wd) - 64'd1);
          if (!q) x[63:32] = '0;
          u = 0; gw = 1; gr = x;
        end
        4'd7: if ((s == 3) == q) begin
          u = 0; gw = 1; gr = getl(vs, idx, s);
        end
        default: ;
      endcase
    end
  endtask

  task automatic run(input logic [31:0] w, input string tag);
    bit u, vw, gw;
    logic [127:0] vr;
    logic [63:0] gr;
    @(negedge clk);
    instr = w;
    instr[9:0] = 10'($urandom);
    vec_src = {$urandom, $urandom, $urandom, $urandom};
    vec_old = {$urandom, $urandom, $urandom, $urandom};
    gen_src = {$urandom, $urandom};
    in_valid = 1'b1;
    model(instr, vec_src, vec_old, gen_src, u, vw, gw, vr, gr);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 out_valid", {127'd0, out_valid}, 128'd1);
    if (u) chk("R11 undef/we", {125'd0, undef_insn, vec_we, gen_we}, {125'd0, 3'b100});
    else   chk("R12 undef/we", {125'd0, undef_insn, vec_we, gen_we}, {125'd0, 1'b0, vw, gw});
    if (!u && vw) chk({tag, " vec_result"}, vec_result, vr);
    if (!u && gw) chk({tag, " gen_result"}, {64'd0, gen_result}, {64'd0, gr});
  endtask

  function automatic string tag_of(input bit op, input logic [3:0] i4, input logic [4:0] i5);
    if (i5[3:0] == 4'd0) return "R3";
    if (op) return "R7";
    case (i4)
      4'd0: return "R4";
      4'd1: return "R5";
      4'd3: return "R6";
      4'd5: return "R8";
      4'd7: return "R9";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {124'd0, out_valid, vec_we, gen_we, undef_insn}, 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {124'd0, out_valid, vec_we, gen_we, undef_insn}, 128'd0);
    // R10 scalar form over every imm5
    for (int i5 = 0; i5 < 32; i5++)
      run({11'b01011110000, 5'(i5), 6'b000001, 10'd0}, (i5 % 16 == 0) ? "R3" : "R10");
    // scalar-like words with wrong imm4 or op are undefined (R11)
    for (int i4 = 1; i4 < 16; i4++)
      run({11'b01011110000, 5'd1, 1'b0, 4'(i4), 1'b1, 10'd0}, "R11");
    run({11'b01111110000, 5'd2, 6'b000001, 10'd0}, "R11");
    // vector form: every op, Q, imm4, imm5
    for (int op = 0; op < 2; op++)
      for (int q = 0; q < 2; q++)
        for (int i4 = 0; i4 < 16; i4++)
          for (int i5 = 0; i5 < 32; i5++)
            run({1'b0, 1'(q), 1'(op), 8'b01110000, 5'(i5), 1'b0, 4'(i4), 1'b1, 10'd0},
                tag_of(1'(op), 4'(i4), 5'(i5)));
    // broken fixed bits are undefined (R11)
    run({1'b0, 1'b1, 1'b0, 8'b01110000, 5'd1, 1'b0, 4'd0, 1'b0, 10'd0}, "R11");
    run({1'b0, 1'b1, 1'b0, 8'b01110000, 5'd1, 1'b1, 4'd0, 1'b1, 10'd0}, "R11");
    run({1'b1, 1'b1, 1'b0, 8'b01110000, 5'd1, 1'b0, 4'd0, 1'b1, 10'd0}, "R11");
    // R2: idle cycle gives no valid output
    @(negedge clk);
    chk("R2 idle out_valid", {127'd0, out_valid}, 128'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule